// File: doc/BRIEF.md
# Transmit Descriptor Ring Manager

This block keeps a small circular set of transmit descriptors and moves each frame from a host-side writer to a transmit engine. The host fills the buffer of the current descriptor in chunks: it asks to store some number of bytes and the block answers in the same cycle with how many it takes and the byte address in the shared buffer space where they go. A send command hands the filled descriptor to the engine. It sets the ownership flag, records the frame length and moves the host to the next descriptor.

The engine sees the oldest descriptor that it owns, with both descriptor words. A completion pulse from the engine gives that descriptor back to the host. While a descriptor is owned by the engine, host writes to it are refused. This is what stops the host from overrunning a ring that is still being transmitted. A monitor port lets any descriptor's two words be read at any time.

Top module: `txr_ring_mgr`

## Requirements
- R1: After reset the current index and write offset are 0, no descriptor is owned by the engine, every stored length is 0, `eng_valid` is 0 and `eng_tx_req` is 0.
- R2: Descriptor word 0 holds ownership in bit 31 and the last-in-ring flag in bit 30. Bits 29:28 hold the frame-position code 2'b11 (whole frame in one buffer). All other bits are 0. Only descriptor DEPTH-1 has bit 30 set, so with the default depth an idle word 0 reads 0x30000000, or 0x70000000 for the last descriptor.
- R3: While the current descriptor is owned by the engine, a write request is refused: `host_wr_acc` is 0 and the write offset does not change.
- R4: An accepted write takes min(requested length, 1514 − offset) bytes, reported on `host_wr_acc` in the same cycle. The offset grows by that amount on the next cycle.
- R5: `host_wr_addr` equals current index × 1600 + write offset.
- R6: A send while the write offset is 0 changes nothing.
- R7: A send with a non-zero offset, on a descriptor the host owns, has these effects one cycle later. The descriptor is owned by the engine. Word 1 holds the offset in bits 31:16 and 0 in bits 15:0. The offset is 0. The index has advanced and wraps to 0 after descriptor DEPTH-1.
- R8: `eng_tx_req` pulses for exactly the one cycle after a send accepted under R7, and only if `tx_en` was 1 at that send.
- R9: The engine port shows the oldest descriptor owned by the engine (index and both words), with `eng_valid` set while that descriptor is owned. `eng_done` while `eng_valid` is 1 returns it to the host and moves to the next descriptor. `eng_done` while `eng_valid` is 0 has no effect.
- R10: A write request in the same cycle as a send is refused (`host_wr_acc` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmission enabled; gates the request strobe |
| host_wr_req | input | 1 | Host asks to store a chunk |
| host_wr_len | input | 16 | Bytes requested |
| host_wr_acc | output | 16 | Bytes accepted this cycle |
| host_wr_addr | output | $clog2(DEPTH*BUF_BYTES) | Buffer-space byte address for the chunk |
| host_send | input | 1 | Submit the current descriptor |
| host_idx | output | $clog2(DEPTH) | Current host descriptor index |
| host_offset | output | 16 | Current write offset |
| mon_idx | input | $clog2(DEPTH) | Descriptor selected for inspection |
| mon_w0 | output | 32 | Word 0 of the selected descriptor |
| mon_w1 | output | 32 | Word 1 of the selected descriptor |
| eng_valid | output | 1 | Oldest engine descriptor is owned by the engine |
| eng_idx | output | $clog2(DEPTH) | Index of that descriptor |
| eng_w0 | output | 32 | Its word 0 |
| eng_w1 | output | 32 | Its word 1 |
| eng_tx_req | output | 1 | One-cycle transmit request strobe |
| eng_done | input | 1 | Engine completion pulse |

## Verification
The accepted count and the write address are combinational. The bench samples them 1 ns after it drives a request, within the same cycle. Offset, index, ownership, length and engine pointer all take effect one clock edge after the command. The bench therefore holds each command across a single rising edge and reads these values at the next falling edge. The request strobe is due in the cycle after the send's edge. A scoreboard queue holds the host index expected at each strobe, and a monitor pops one entry each time it sees the strobe at a falling edge. An unexpected strobe, or an entry left in the queue at the end, counts as a failure.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int FRAME_LEN_W = 16;
    localparam logic [1:0] POS_ONE_BUF = 2'b11;

    function automatic logic [31:0] pack_w0(input logic own, input logic last);
        logic [31:0] w;
        w        = '0;
        w[31]    = own;
        w[30]    = last;
        w[29:28] = POS_ONE_BUF;
        return w;
    endfunction

    function automatic logic [31:0] pack_w1(input logic [FRAME_LEN_W-1:0] len);
        return {len, {(32-FRAME_LEN_W){1'b0}}};
    endfunction
endpackage

// File: rtl/txr_desc_bank.sv
module txr_desc_bank #(
    parameter int DEPTH = 4,
    parameter int LEN_W = 16,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IW-1:0]    set_idx,
    input  logic [LEN_W-1:0] set_len,
    input  logic             clr_en,
    input  logic [IW-1:0]    clr_idx,
    output logic [DEPTH-1:0] own_o,
    output logic [LEN_W-1:0] len_o [DEPTH]
);
    typedef struct packed {
        logic             own;
        logic [LEN_W-1:0] len;
    } slot_t;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (set_en && set_idx == IW'(g)) begin
                slot_d.own = 1'b1;
                slot_d.len = set_len;
            end else if (clr_en && clr_idx == IW'(g)) begin
                slot_d.own = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign own_o[g] = slot_q.own;
        assign len_o[g] = slot_q.len;
    end

    p_set_owns_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> own_o[$past(set_idx)]);

    p_done_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !own_o[$past(clr_idx)]);
endmodule

// File: rtl/txr_host_side.sv
module txr_host_side #(
    parameter int DEPTH     = 4,
    parameter int BUF_BYTES = 1600,
    parameter int MAX_FRAME = 1514,
    parameter int LEN_W     = 16,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int AW = $clog2(DEPTH * BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             wr_req,
    input  logic [LEN_W-1:0] wr_len,
    input  logic             send,
    input  logic             cur_own,
    output logic [LEN_W-1:0] wr_acc,
    output logic [AW-1:0]    wr_addr,
    output logic [IW-1:0]    idx_o,
    output logic [LEN_W-1:0] off_o,
    output logic             submit,
    output logic             tx_req_o
);
    typedef struct packed {
        logic [IW-1:0]    idx;
        logic [LEN_W-1:0] off;
        logic             req;
    } hs_t;

    hs_t hs_d, hs_q;
    logic [LEN_W-1:0] room;

    always_comb begin
        hs_d   = hs_q;
        room   = LEN_W'(MAX_FRAME) - hs_q.off;
        submit = send && (hs_q.off != '0) && !cur_own;
        wr_acc = '0;
        if (wr_req && !send && !cur_own)
            wr_acc = (wr_len < room) ? wr_len : room;
        hs_d.req = submit && tx_en;
        if (submit) begin
            hs_d.off = '0;
            hs_d.idx = (hs_q.idx == IW'(DEPTH-1)) ? '0 : hs_q.idx + 1'b1;
        end else begin
            hs_d.off = hs_q.off + wr_acc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign wr_addr  = AW'(hs_q.idx) * AW'(BUF_BYTES) + AW'(hs_q.off);
    assign idx_o    = hs_q.idx;
    assign off_o    = hs_q.off;
    assign tx_req_o = hs_q.req;

    p_refuse_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && cur_own && !send) |=> $stable(off_o));

    p_offset_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        off_o <= LEN_W'(MAX_FRAME));

    p_empty_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (send && off_o == '0) |=> $stable(idx_o));

    p_send_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (send && off_o != '0 && !cur_own) |=> (off_o == '0));

    p_strobe_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |-> $past(send && tx_en));

    p_mixed_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && send) |-> (wr_acc == '0));
endmodule

// File: rtl/txr_done_ptr.sv
module txr_done_ptr #(
    parameter int DEPTH = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [DEPTH-1:0] own,
    output logic [IW-1:0]    old_idx,
    output logic             clr_en
);
    typedef struct packed {
        logic [IW-1:0] old;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d   = dp_q;
        clr_en = done && own[dp_q.old];
        if (clr_en)
            dp_d.old = (dp_q.old == IW'(DEPTH-1)) ? '0 : dp_q.old + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign old_idx = dp_q.old;

    p_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !own[old_idx]) |=> $stable(old_idx));
endmodule

// File: rtl/txr_ring_mgr.sv
module txr_ring_mgr #(
    parameter int DEPTH     = 4,
    parameter int BUF_BYTES = 1600,
    parameter int MAX_FRAME = 1514
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    tx_en,
    input  logic                                    host_wr_req,
    input  logic [15:0]                             host_wr_len,
    output logic [15:0]                             host_wr_acc,
    output logic [$clog2(DEPTH*BUF_BYTES)-1:0]      host_wr_addr,
    input  logic                                    host_send,
    output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0]  host_idx,
    output logic [15:0]                             host_offset,
    input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0]  mon_idx,
    output logic [31:0]                             mon_w0,
    output logic [31:0]                             mon_w1,
    output logic                                    eng_valid,
    output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0]  eng_idx,
    output logic [31:0]                             eng_w0,
    output logic [31:0]                             eng_w1,
    output logic                                    eng_tx_req,
    input  logic                                    eng_done
);
    import txr_pkg::*;

    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LEN_W = FRAME_LEN_W;

    logic [DEPTH-1:0] own;
    logic [LEN_W-1:0] len [DEPTH];
    logic             submit;
    logic             clr_en;
    logic [IW-1:0]    old_idx;

    txr_host_side #(
        .DEPTH(DEPTH), .BUF_BYTES(BUF_BYTES), .MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W)
    ) u_host (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
        .wr_req(host_wr_req), .wr_len(host_wr_len), .send(host_send),
        .cur_own(own[host_idx]),
        .wr_acc(host_wr_acc), .wr_addr(host_wr_addr),
        .idx_o(host_idx), .off_o(host_offset),
        .submit(submit), .tx_req_o(eng_tx_req)
    );

    txr_desc_bank #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .set_en(submit), .set_idx(host_idx), .set_len(host_offset),
        .clr_en(clr_en), .clr_idx(old_idx),
        .own_o(own), .len_o(len)
    );

    txr_done_ptr #(.DEPTH(DEPTH)) u_done (
        .clk(clk), .rst_n(rst_n), .done(eng_done), .own(own),
        .old_idx(old_idx), .clr_en(clr_en)
    );

    assign mon_w0    = pack_w0(own[mon_idx], mon_idx == IW'(DEPTH-1));
    assign mon_w1    = pack_w1(len[mon_idx]);
    assign eng_idx   = old_idx;
    assign eng_valid = own[old_idx];
    assign eng_w0    = pack_w0(own[old_idx], old_idx == IW'(DEPTH-1));
    assign eng_w1    = pack_w1(len[old_idx]);

    p_engine_view_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> eng_w0[31]);
endmodule

// File: tb/txr_ring_mgr_tb_top.sv
module txr_ring_mgr_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic host_wr_req = 1'b0;
    logic [15:0] host_wr_len = '0;
    logic [15:0] host_wr_acc;
    logic [12:0] host_wr_addr;
    logic host_send = 1'b0;
    logic [1:0] host_idx;
    logic [15:0] host_offset;
    logic [1:0] mon_idx = '0;
    logic [31:0] mon_w0, mon_w1, eng_w0, eng_w1;
    logic eng_valid, eng_tx_req;
    logic [1:0] eng_idx;
    logic eng_done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int exp_q[$];

    always #5 clk = ~clk;

    txr_ring_mgr dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
        .host_wr_req(host_wr_req), .host_wr_len(host_wr_len),
        .host_wr_acc(host_wr_acc), .host_wr_addr(host_wr_addr),
        .host_send(host_send), .host_idx(host_idx), .host_offset(host_offset),
        .mon_idx(mon_idx), .mon_w0(mon_w0), .mon_w1(mon_w1),
        .eng_valid(eng_valid), .eng_idx(eng_idx), .eng_w0(eng_w0), .eng_w1(eng_w1),
        .eng_tx_req(eng_tx_req), .eng_done(eng_done)
    );

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", r, act, exp);
        end
    endtask

    // monitor: each strobe pops the host index expected after that send
    always @(negedge clk) begin
        if (rst_n && eng_tx_req) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected strobe", 32'd1, 32'd0);
            end else begin
                int e;
                e = exp_q.pop_front();
                check("R8 strobe host_idx", 32'(host_idx), 32'(e));
            end
        end
    end

    // write request: returns accepted count and address sampled in-cycle
    task automatic wr(input int len, input int exp_acc, input int exp_addr, input string r);
        @(negedge clk);
        host_wr_req = 1'b1;
        host_wr_len = 16'(len);
        #1;
        check({r, " acc"}, 32'(host_wr_acc), 32'(exp_acc));
        if (exp_addr >= 0) check("R5 addr", 32'(host_wr_addr), 32'(exp_addr));
        @(negedge clk);
        host_wr_req = 1'b0;
    endtask

    task automatic snd(input bit en, input bit expect_strobe, input int exp_next);
        @(negedge clk);
        tx_en = en;
        host_send = 1'b1;
        if (expect_strobe) exp_q.push_back(exp_next);
        @(negedge clk);
        host_send = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic peek(input int i, input logic [31:0] w0, input logic [31:0] w1, input string r);
        mon_idx = 2'(i);
        #1;
        check({r, " w0"}, mon_w0, w0);
        check({r, " w1"}, mon_w1, w1);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R2 reset state and word encodings
        check("R1 idx", 32'(host_idx), 0);
        check("R1 offset", 32'(host_offset), 0);
        check("R1 eng_valid", 32'(eng_valid), 0);
        check("R1 strobe", 32'(eng_tx_req), 0);
        for (int i = 0; i < 4; i++)
            peek(i, (i == 3) ? 32'h7000_0000 : 32'h3000_0000, 32'h0, "R1 R2 reset desc");

        // R4 / R5 chunks into descriptor 0
        wr(100, 100, 0, "R4 first chunk");
        wr(50, 50, 100, "R4 second chunk");
        check("R4 offset", 32'(host_offset), 150);

        // R7 / R8 send with tx enabled
        snd(1'b1, 1'b1, 1);
        peek(0, 32'hB000_0000, 32'(150) << 16, "R7 desc0 submitted");
        check("R7 idx", 32'(host_idx), 1);
        check("R7 offset", 32'(host_offset), 0);
        check("R9 eng_valid", 32'(eng_valid), 1);
        check("R9 eng_idx", 32'(eng_idx), 0);
        check("R9 eng_w1", eng_w1, 32'(150) << 16);

        // R6 empty send
        snd(1'b1, 1'b0, 0);
        check("R6 idx unchanged", 32'(host_idx), 1);
        peek(1, 32'h3000_0000, 32'h0, "R6 desc1 untouched");

        // R4 cap at 1514, then full
        wr(2000, 1514, 1600, "R4 capped");
        wr(10, 0, 1600 + 1514, "R4 full");
        check("R4 offset at cap", 32'(host_offset), 1514);

        // R8 send with tx disabled: no strobe
        snd(1'b0, 1'b0, 0);
        check("R8 idx after quiet send", 32'(host_idx), 2);
        peek(1, 32'hB000_0000, 32'(1514) << 16, "R7 desc1");

        // R10 write in same cycle as send
        wr(5, 5, 3200, "R4 desc2");
        @(negedge clk);
        tx_en = 1'b1;
        host_send = 1'b1;
        host_wr_req = 1'b1;
        host_wr_len = 16'd7;
        exp_q.push_back(3);
        #1;
        check("R10 acc", 32'(host_wr_acc), 0);
        @(negedge clk);
        host_send = 1'b0;
        host_wr_req = 1'b0;
        check("R10 offset", 32'(host_offset), 0);
        peek(2, 32'hB000_0000, 32'(5) << 16, "R10 desc2 len");

        // R7 wrap on last descriptor
        wr(1, 1, 4800, "R4 desc3");
        snd(1'b1, 1'b1, 0);
        check("R7 wrap", 32'(host_idx), 0);
        peek(3, 32'hF000_0000, 32'(1) << 16, "R2 R7 last desc");

        // R3 ring full, descriptor 0 still owned
        wr(20, 0, 0, "R3 refused");
        check("R3 offset", 32'(host_offset), 0);
        snd(1'b1, 1'b0, 0);
        check("R3 R6 idx", 32'(host_idx), 0);

        // R9 completion
        done_pulse();
        check("R9 eng_idx", 32'(eng_idx), 1);
        peek(0, 32'h3000_0000, 32'(150) << 16, "R9 desc0 returned");
        wr(20, 20, 20 - 20, "R3 R4 accepted after return");
        check("R4 offset", 32'(host_offset), 20);
        done_pulse();
        done_pulse();
        done_pulse();
        check("R9 all returned", 32'(eng_valid), 0);
        check("R9 ptr wrapped", 32'(eng_idx), 0);
        done_pulse();
        check("R9 idle done", 32'(eng_idx), 0);

        repeat (3) @(negedge clk);
        check("R8 queue drained", 32'(exp_q.size()), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule